// File: doc/BRIEF.md
# Multi-Source Byte Read Port

This block is the host-facing byte read port of a flash page controller. The most recent command decides where each single-byte read is taken from. The choices are the page buffer addressed directly, the page buffer with the two low address bits inverted, the bytes of two device-status words that hold the identifier, or the low byte of the second status word. A byte offset moves forward by one on every byte read, in every mode. A burst read request only moves the offset, and it does so only when the page buffer is the selected source. The burst data itself is carried by a separate direct path.

The same offset also drives a buffer write path. A write presents up to `LANES` bytes packed in one word. The accepted length is limited so that no byte lands past the end of the page-plus-spare area. The accepted length is added to the offset and to a running total of bytes written, and a program command clears that total. Commands enter as a kind code and a signed column value. The status words come from elsewhere in the controller and are sampled whenever a read is requested.

Top module: `alt_read_port`

## Requirements
- R1: After a synchronous active-low reset, `rd_valid` is 0, `rd_data` is 0x00 and `wr_total` is 0. The source is the page buffer and the offset is 0.
- R2: `cmd_kind` is decoded as follows: 1 = identifier, 2 = status, 3 = parameter, 4 = program, and any other value = plain data. An identifier command sets the offset to 0. Every other command sets the offset to max(`cmd_col`, 0), with `cmd_col` read as two's complement. Status, parameter and identifier commands select their own source, and all other codes select the page buffer.
- R3: In identifier mode, an offset n below 4 returns bits [31-8n -: 8] of `stat_word1`, so offset 0 gives bits 31:24. Any offset of 4 or more returns bits 31:24 of `stat_word2`.
- R4: In status mode every byte read returns bits 7:0 of `stat_word2`.
- R5: In parameter mode a read returns the buffer byte at address offset XOR 3.
- R6: In data mode a read returns the buffer byte at the offset. Any buffer address at or above `PAGE_BYTES + SPARE_BYTES` (default 2112) reads as 0x00.
- R7: A byte read in cycle k drives `rd_data` and sets `rd_valid` for exactly one cycle after the clock edge that samples the request. The offset then rises by one in every mode, and it wraps modulo 2^13 at the default sizes.
- R8: A burst request adds `burst_len` to the offset in data mode and leaves the offset unchanged in every other mode.
- R9: A write request is granted g = min(`wr_len`, `LANES`, limit - offset) bytes, with g = 0 when the offset is at or past the limit. Byte lane i is `wr_data[8i+7:8i]` and is stored at offset + i for every i < g. Both the offset and `wr_total` rise by g.
- R10: A program command clears `wr_total` to 0 and selects data mode with the offset set from the column.
- R11: Only one request acts in any cycle, with priority command, then byte read, then burst, then write. Lower-priority requests in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 3 | Command kind code |
| cmd_col | input | 16 | Signed column value sent with the command |
| stat_word1 | input | 32 | First device status word (identifier bytes 0-3) |
| stat_word2 | input | 32 | Second device status word |
| rd_byte_req | input | 1 | Single-byte read request |
| burst_req | input | 1 | Burst read request (moves the offset only) |
| burst_len | input | 8 | Burst length in bytes |
| wr_req | input | 1 | Buffer write request |
| wr_len | input | 3 | Requested write length in bytes |
| wr_data | input | 32 | Write bytes, with lane 0 in the low byte |
| rd_data | output | 8 | Registered read byte |
| rd_valid | output | 1 | One-cycle marker for `rd_data` |
| wr_total | output | 16 | Running count of bytes accepted by writes |

## Verification
Random sequences mix all four command kinds with column values that may be negative, reads, bursts and writes of random lengths. A bench model predicts every read byte, so each mode's address path is separated from the others: XOR 3 against a direct address, and status-word bytes against buffer bytes. Directed cases cover write clamping at the limit edge, bursts that must be ignored in parameter mode, identifier offsets both sides of 4, and requests that collide in one cycle. A collision shows that the priority order decides which request moves the offset.

// File: rtl/arp_pkg.sv
// Shared types for the multi-source byte read port.
// Assumes: the command kind field is 3 bits wide, and codes 5..7 count as plain data.
package arp_pkg;
    typedef enum logic [2:0] {
        KIND_DATA    = 3'd0,
        KIND_IDENT   = 3'd1,
        KIND_STATUS  = 3'd2,
        KIND_PARAM   = 3'd3,
        KIND_PROGRAM = 3'd4
    } cmd_kind_e;

    typedef enum logic [1:0] {
        SRC_DATA   = 2'd0,
        SRC_IDENT  = 2'd1,
        SRC_STATUS = 2'd2,
        SRC_PARAM  = 2'd3
    } src_mode_e;
endpackage

// File: rtl/arp_clamp.sv
// Write-length limiter: grants the smaller of the requested length, the lane
// count and the bytes left before the buffer limit.
// Assumes: LANES fits in GW bits; combinational only.
module arp_clamp #(
    parameter int OFF_W = 13,
    parameter int LIMIT = 2112,
    parameter int LANES = 4,
    parameter int GW    = 3
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [GW-1:0]    req_len,
    output logic [GW-1:0]    grant
);
    localparam logic [OFF_W-1:0] LIM = OFF_W'(LIMIT);

    logic [OFF_W-1:0] room;
    logic [OFF_W-1:0] want;

    // Compute room to the limit and the lane-capped request, then take the minimum.
    always_comb begin
        room  = (offset < LIM) ? (LIM - offset) : '0;
        want  = (req_len > GW'(LANES)) ? OFF_W'(LANES) : OFF_W'(req_len);
        grant = (want < room) ? GW'(want) : GW'(room);
    end
endmodule

// File: rtl/arp_buffer.sv
// Page buffer RAM with LANES byte write lanes and one asynchronous byte read.
// Assumes: write addresses stay below DEPTH (the limiter guarantees it).
// The storage is not reset, and reads at or past DEPTH return zero.
module arp_buffer #(
    parameter int DEPTH = 2112,
    parameter int OFF_W = 13,
    parameter int LANES = 4,
    parameter int GW    = 3
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [OFF_W-1:0]   wr_base,
    input  logic [GW-1:0]      wr_count,
    input  logic [8*LANES-1:0] wr_data,
    input  logic [OFF_W-1:0]   rd_addr,
    output logic [7:0]         rd_byte
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] lane_addr [LANES];
    logic [LANES-1:0] lane_on;

    // Per-lane address and enable.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] full_addr;
        always_comb begin
            full_addr    = wr_base + OFF_W'(i);
            lane_addr[i] = full_addr[AW-1:0];
            lane_on[i]   = wr_en && (GW'(i) < wr_count);
        end
    end

    // Store every enabled lane.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_on[i]) begin
                mem[lane_addr[i]] <= wr_data[8*i +: 8];
            end
        end
    end

    // Single-cycle read with out-of-range addresses forced to zero.
    always_comb begin
        if (rd_addr < OFF_W'(DEPTH)) rd_byte = mem[rd_addr[AW-1:0]];
        else                         rd_byte = 8'h00;
    end
endmodule

// File: rtl/arp_byte_sel.sv
// Source selector: forms the buffer read address for the current mode and picks
// the returned byte from the buffer or from the status words.
// Assumes: combinational only; the caller registers the result.
module arp_byte_sel
    import arp_pkg::*;
#(
    parameter int OFF_W = 13
) (
    input  src_mode_e        mode,
    input  logic [OFF_W-1:0] offset,
    input  logic [31:0]      stat_word1,
    input  logic [31:0]      stat_word2,
    input  logic [7:0]       buf_byte,
    output logic [OFF_W-1:0] buf_addr,
    output logic [7:0]       sel_byte
);
    logic low_id;

    // Parameter bytes undo big-endian word packing by inverting the two low address bits.
    always_comb begin
        buf_addr = (mode == SRC_PARAM) ? (offset ^ OFF_W'(3)) : offset;
    end

    // Choose the byte source for the active mode.
    always_comb begin
        low_id = (offset < OFF_W'(4));
        unique case (mode)
            SRC_IDENT: begin
                if (low_id) begin
                    unique case (offset[1:0])
                        2'd0: sel_byte = stat_word1[31:24];
                        2'd1: sel_byte = stat_word1[23:16];
                        2'd2: sel_byte = stat_word1[15:8];
                        default: sel_byte = stat_word1[7:0];
                    endcase
                end else begin
                    sel_byte = stat_word2[31:24];
                end
            end
            SRC_STATUS: sel_byte = stat_word2[7:0];
            default:    sel_byte = buf_byte;
        endcase
    end
endmodule

// File: rtl/arp_cursor.sv
// Cursor state: source mode, byte offset and running write total. Commands,
// reads, bursts and writes arrive already prioritized, with at most one go per cycle.
// Assumes: COL_W >= OFF_W; synchronous active-low reset.
module arp_cursor
    import arp_pkg::*;
#(
    parameter int OFF_W   = 13,
    parameter int COL_W   = 16,
    parameter int BURST_W = 8,
    parameter int GW      = 3,
    parameter int WSZ_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_go,
    input  logic [2:0]              cmd_kind,
    input  logic signed [COL_W-1:0] cmd_col,
    input  logic                    rd_go,
    input  logic                    burst_go,
    input  logic [BURST_W-1:0]      burst_len,
    input  logic                    wr_go,
    input  logic [GW-1:0]           wr_grant,
    output src_mode_e               mode,
    output logic [OFF_W-1:0]        offset,
    output logic [WSZ_W-1:0]        wr_total
);
    logic [OFF_W-1:0] col_off;
    cmd_kind_e        kind;

    // Column clipped at zero, and the decoded command kind.
    always_comb begin
        col_off = (cmd_col < 0) ? '0 : cmd_col[OFF_W-1:0];
        kind    = cmd_kind_e'(cmd_kind);
    end

    // Update the mode, offset and write total, one request per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= SRC_DATA;
            offset   <= '0;
            wr_total <= '0;
        end else if (cmd_go) begin
            unique case (kind)
                KIND_IDENT:  begin mode <= SRC_IDENT;  offset <= '0;      end
                KIND_STATUS: begin mode <= SRC_STATUS; offset <= col_off; end
                KIND_PARAM:  begin mode <= SRC_PARAM;  offset <= col_off; end
                default:     begin mode <= SRC_DATA;   offset <= col_off; end
            endcase
            if (kind == KIND_PROGRAM) wr_total <= '0;
        end else if (rd_go) begin
            offset <= offset + OFF_W'(1);
        end else if (burst_go) begin
            if (mode == SRC_DATA) offset <= offset + OFF_W'(burst_len);
        end else if (wr_go) begin
            offset   <= offset + OFF_W'(wr_grant);
            wr_total <= wr_total + WSZ_W'(wr_grant);
        end
    end
endmodule

// File: rtl/alt_read_port.sv
// Top of the multi-source byte read port. Prioritizes the request inputs,
// updates the cursor, writes the page buffer and registers the selected byte.
// Assumes: the status words are stable in the cycle a byte read is requested.
module alt_read_port
    import arp_pkg::*;
#(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int LANES       = 4,
    parameter int BURST_W     = 8,
    parameter int COL_W       = 16,
    parameter int WSZ_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_kind,
    input  logic signed [COL_W-1:0] cmd_col,
    input  logic [31:0]             stat_word1,
    input  logic [31:0]             stat_word2,
    input  logic                    rd_byte_req,
    input  logic                    burst_req,
    input  logic [BURST_W-1:0]      burst_len,
    input  logic                    wr_req,
    input  logic [$clog2(LANES+1)-1:0] wr_len,
    input  logic [8*LANES-1:0]      wr_data,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    output logic [WSZ_W-1:0]        wr_total
);
    localparam int DEPTH = PAGE_BYTES + SPARE_BYTES;
    localparam int AW    = $clog2(DEPTH);
    localparam int OFF_W = AW + 1;
    localparam int GW    = $clog2(LANES + 1);

    logic             rd_go, burst_go, wr_go;
    src_mode_e        cur_mode;
    logic [OFF_W-1:0] cur_off;
    logic [GW-1:0]    grant;
    logic [OFF_W-1:0] buf_addr;
    logic [7:0]       buf_byte, sel_byte;

    // Fixed priority: command, byte read, burst, write.
    always_comb begin
        rd_go    = rd_byte_req && !cmd_valid;
        burst_go = burst_req && !cmd_valid && !rd_byte_req;
        wr_go    = wr_req && !cmd_valid && !rd_byte_req && !burst_req;
    end

    arp_clamp #(.OFF_W(OFF_W), .LIMIT(DEPTH), .LANES(LANES), .GW(GW)) u_clamp (
        .offset(cur_off), .req_len(wr_len), .grant(grant)
    );

    arp_cursor #(.OFF_W(OFF_W), .COL_W(COL_W), .BURST_W(BURST_W), .GW(GW), .WSZ_W(WSZ_W)) u_cursor (
        .clk(clk), .rst_n(rst_n),
        .cmd_go(cmd_valid), .cmd_kind(cmd_kind), .cmd_col(cmd_col),
        .rd_go(rd_go), .burst_go(burst_go), .burst_len(burst_len),
        .wr_go(wr_go), .wr_grant(grant),
        .mode(cur_mode), .offset(cur_off), .wr_total(wr_total)
    );

    arp_buffer #(.DEPTH(DEPTH), .OFF_W(OFF_W), .LANES(LANES), .GW(GW)) u_buffer (
        .clk(clk), .wr_en(wr_go), .wr_base(cur_off), .wr_count(grant),
        .wr_data(wr_data), .rd_addr(buf_addr), .rd_byte(buf_byte)
    );

    arp_byte_sel #(.OFF_W(OFF_W)) u_sel (
        .mode(cur_mode), .offset(cur_off),
        .stat_word1(stat_word1), .stat_word2(stat_word2),
        .buf_byte(buf_byte), .buf_addr(buf_addr), .sel_byte(sel_byte)
    );

    // Register the read byte and its one-cycle valid marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= sel_byte;
        end
    end
endmodule

// File: rtl/arp_checker.sv
// Protocol checker for alt_read_port, attached with bind.
// Assumes: it sees the port signals plus the cursor mode, offset and write total.
module arp_checker
    import arp_pkg::*;
#(
    parameter int OFF_W = 13,
    parameter int LIMIT = 2112,
    parameter int WSZ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_kind,
    input logic [31:0]      stat_word2,
    input logic             rd_byte_req,
    input logic             burst_req,
    input logic             wr_req,
    input logic [7:0]       rd_data,
    input logic             rd_valid,
    input logic [WSZ_W-1:0] wr_total,
    input src_mode_e        mode,
    input logic [OFF_W-1:0] offset
);
    // R7
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_req && !cmd_valid) |=> rd_valid);
    // R7
    rd_offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_req && !cmd_valid) |=> (offset == OFF_W'($past(offset) + OFF_W'(1))));
    // R11
    cmd_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !rd_valid);
    // R2
    ident_zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd1) |=> (offset == '0 && mode == SRC_IDENT));
    // R4
    status_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_req && !cmd_valid && mode == SRC_STATUS) |=> (rd_data == $past(stat_word2[7:0])));
    // R8
    burst_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_req && !cmd_valid && !rd_byte_req && mode != SRC_DATA) |=> $stable(offset));
    // R10
    program_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd4) |=> (wr_total == '0));
    // R9
    write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !cmd_valid && !rd_byte_req && !burst_req && offset >= OFF_W'(LIMIT))
        |=> ($stable(wr_total) && $stable(offset)));
endmodule

bind alt_read_port arp_checker #(.OFF_W(OFF_W), .LIMIT(DEPTH), .WSZ_W(WSZ_W)) u_arp_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .stat_word2(stat_word2), .rd_byte_req(rd_byte_req), .burst_req(burst_req),
    .wr_req(wr_req), .rd_data(rd_data), .rd_valid(rd_valid), .wr_total(wr_total),
    .mode(cur_mode), .offset(cur_off)
);

// File: tb/alt_read_port_bench.sv
// Bench for alt_read_port: a seeded random operation mix plus directed corners,
// checked against a bench-side model of the buffer, mode, offset and write total.
module alt_read_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 2112;
    localparam int LANES      = 4;
    localparam int N_RANDOM   = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = '0;
    logic signed [15:0] cmd_col = '0;
    logic [31:0] stat_word1 = '0, stat_word2 = '0;
    logic        rd_byte_req = 1'b0, burst_req = 1'b0, wr_req = 1'b0;
    logic [7:0]  burst_len = '0;
    logic [2:0]  wr_len = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [15:0] wr_total;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state (mode: 0 data, 1 identifier, 2 status, 3 parameter).
    logic [7:0]  mdl [LIMIT];
    int          m_mode = 0;
    logic [12:0] m_off  = '0;
    logic [15:0] m_tot  = '0;

    alt_read_port u_alt_read_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_col(cmd_col), .stat_word1(stat_word1), .stat_word2(stat_word2),
        .rd_byte_req(rd_byte_req), .burst_req(burst_req), .burst_len(burst_len),
        .wr_req(wr_req), .wr_len(wr_len), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_total(wr_total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [31:0] s1, input logic [31:0] s2);
        logic [12:0] a;
        case (m_mode)
            1: return (m_off < 13'd4) ? 8'((s1 >> ((3 - int'(m_off)) * 8)) & 32'hFF) : s2[31:24];
            2: return s2[7:0];
            3: begin a = m_off ^ 13'd3; return (a < 13'(LIMIT)) ? mdl[a] : 8'h00; end
            default: return (m_off < 13'(LIMIT)) ? mdl[m_off] : 8'h00;
        endcase
    endfunction

    function automatic string mode_tag();
        case (m_mode)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // One operation: drive for one cycle, predict, then check at the next falling edge.
    task automatic run_op(input bit c, input logic [2:0] k, input logic signed [15:0] col,
                          input bit r, input bit b, input logic [7:0] bl,
                          input bit w, input logic [2:0] wl, input logic [31:0] wd,
                          input string note);
        logic [7:0] eb;
        string      tg;
        int         g, room;
        @(negedge clk);
        cmd_valid = c; cmd_kind = k; cmd_col = col;
        rd_byte_req = r; burst_req = b; burst_len = bl;
        wr_req = w; wr_len = wl; wr_data = wd;
        stat_word1 = $urandom; stat_word2 = $urandom;
        eb = exp_byte(stat_word1, stat_word2);
        tg = mode_tag();
        if (c) begin
            case (k)
                3'd1: m_mode = 1;
                3'd2: m_mode = 2;
                3'd3: m_mode = 3;
                default: m_mode = 0;
            endcase
            m_off = (k == 3'd1) ? 13'd0 : ((col < 0) ? 13'd0 : col[12:0]);
            if (k == 3'd4) m_tot = '0;
        end else if (r) begin
            m_off = m_off + 13'd1;
        end else if (b) begin
            if (m_mode == 0) m_off = m_off + 13'(bl);
        end else if (w) begin
            room = (m_off < 13'(LIMIT)) ? LIMIT - int'(m_off) : 0;
            g = int'(wl);
            if (g > LANES) g = LANES;
            if (g > room) g = room;
            for (int i = 0; i < g; i++) mdl[int'(m_off) + i] = wd[8*i +: 8];
            m_off = m_off + 13'(g);
            m_tot = m_tot + 16'(g);
        end
        @(negedge clk);
        cmd_valid = 1'b0; rd_byte_req = 1'b0; burst_req = 1'b0; wr_req = 1'b0;
        check({"R7 rd_valid ", note}, 32'(rd_valid), 32'(r && !c));
        if (r && !c) check({tg, " byte ", note}, 32'(rd_data), 32'(eb));
        check({"R9/R10 wr_total ", note}, 32'(wr_total), 32'(m_tot));
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        int x;
        logic signed [15:0] cc;
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < LIMIT; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 rd_data", 32'(rd_data), 32'd0);
        check("R1 wr_total", 32'(wr_total), 32'd0);

        // Fill the whole buffer in data mode (R9 lanes), then try past the limit.
        run_op(1, 3'd0, 16'sd0, 0, 0, 8'd0, 0, 3'd0, 32'd0, "data cmd");
        for (int i = 0; i < LIMIT / LANES; i++)
            run_op(0, 3'd0, 16'sd0, 0, 0, 8'd0, 1, 3'd4, $urandom, "fill");
        run_op(0, 3'd0, 16'sd0, 0, 0, 8'd0, 1, 3'd4, 32'hDEADBEEF, "R9 full limit");
        // R10: program clears the total
        run_op(1, 3'd4, 16'sd2110, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R10 program");
        // R9: clamp at the edge, 2 bytes of 4 granted
        run_op(0, 3'd0, 16'sd0, 0, 0, 8'd0, 1, 3'd4, 32'hA1B2C3D4, "R9 edge clamp");
        run_op(1, 3'd0, 16'sd2109, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R2 col");
        for (int i = 0; i < 4; i++)
            run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R6 edge read");
        // R2/R3: identifier offsets 0..5
        run_op(1, 3'd1, 16'sd77, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R2 ident");
        for (int i = 0; i < 6; i++)
            run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R3 ident read");
        // R5/R8: a parameter-mode burst is ignored
        run_op(1, 3'd3, 16'sd8, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R5 param");
        run_op(0, 3'd0, 16'sd0, 0, 1, 8'd9, 0, 3'd0, 32'd0, "R8 burst ignored");
        for (int i = 0; i < 4; i++)
            run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R5 R8 param read");
        // R2 negative column, then R8 data burst
        run_op(1, 3'd0, -16'sd5, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R2 negative col");
        run_op(0, 3'd0, 16'sd0, 0, 1, 8'd17, 0, 3'd0, 32'd0, "R8 data burst");
        run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R8 after burst");
        // R11: colliding requests
        run_op(0, 3'd0, 16'sd0, 1, 1, 8'd30, 1, 3'd4, 32'h0, "R11 rd over burst/wr");
        run_op(1, 3'd2, 16'sd3, 1, 1, 8'd30, 1, 3'd4, 32'h0, "R11 cmd over all");
        run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R4 status read");
        run_op(1, 3'd0, 16'sd40, 0, 0, 8'd0, 0, 3'd0, 32'd0, "R2 data");
        run_op(0, 3'd0, 16'sd0, 0, 1, 8'd3, 1, 3'd4, 32'h11223344, "R11 burst over wr");
        run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "R11 check offset");

        // Random mix
        for (int n = 0; n < N_RANDOM; n++) begin
            x = int'($urandom % 16);
            if (x < 2) begin
                cc = (($urandom % 4) == 0) ? -16'(($urandom % 50) + 1) : 16'($urandom % 2200);
                run_op(1, 3'($urandom % 6), cc, 0, 0, 8'd0, 0, 3'd0, 32'd0, "rand cmd");
            end else if (x < 10) begin
                run_op(0, 3'd0, 16'sd0, 1, 0, 8'd0, 0, 3'd0, 32'd0, "rand read");
            end else if (x < 12) begin
                run_op(0, 3'd0, 16'sd0, 0, 1, 8'($urandom % 20), 0, 3'd0, 32'd0, "rand burst");
            end else begin
                run_op(0, 3'd0, 16'sd0, 0, 0, 8'd0, 1, 3'($urandom % 6), $urandom, "rand write");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule